// File: doc/BRIEF.md
# Sorted Inactive Context Store

This block keeps the parked thread-group contexts of every warp: a program counter and an activity mask each. All warps share one table of entries. Each warp owns a singly linked list through that table, kept in ascending PC order so that the next context handed back is the one with the lowest PC. Entries that belong to no list are chained on a free list.

Insertions arrive on a valid/ready port. At acceptance a free entry is taken and written, and its index is queued. A list-walking engine then drains the queue in order and links each entry into its warp's list by insertion sort, one list step per cycle. If the queue backs up past a threshold, the engine stops sorting and links the new entry at the head of the list, so that warp's list behaves as a stack. A pop takes the head of one warp's list, answers on the next cycle, and returns the entry to the free list.

Top module: `csort_store`

## Requirements
- R1: After reset every warp list is empty, the table holds NUM_WARPS*ENTRIES_PER_WARP free entries, `ins_ready` is 1 and `resp_valid` is 0.
- R2: `ins_ready` is 1 exactly when a free entry exists and the request queue holds fewer than FIFO_DEPTH requests; a request offered while `ins_ready` is 0 is not stored.
- R3: In sorted mode a new entry is linked directly after the last entry of the leading run of entries whose PC is less than or equal to its own, or at the head when the list is empty or its first PC is greater; equal PCs therefore keep arrival order.
- R4: A sorted insertion that goes at the head completes in the cycle it leaves the queue; otherwise the engine spends one further cycle per entry in the leading run of R3 before linking.
- R5: When a request leaves the queue while the queue holds DEGRADE_AT or more requests, it is linked at the head of its warp's list without comparison.
- R6: An accepted pop (`pop_valid` and `pop_ready`) on a non-empty list gives `resp_valid`=1, `resp_hit`=1 and the head entry's PC and mask on the next cycle, removes that entry from the list and frees it.
- R7: An accepted pop on an empty list gives `resp_valid`=1 with `resp_hit`=0 and PC and mask 0 on the next cycle and changes no list.
- R8: `pop_ready` is 0 exactly while the engine is walking the list of the warp on `pop_warp`; pops of other warps are accepted during a walk, and a request that is about to leave the queue for the warp being popped waits one cycle.
- R9: Queued requests are linked in acceptance order.
- R10: Operations on one warp never change the contents or order of another warp's list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insertion request offered |
| ins_ready | output | 1 | Insertion request can be accepted |
| ins_warp | input | WARP_W | Warp owning the new context |
| ins_pc | input | PC_W | PC of the new context |
| ins_mask | input | MASK_W | Activity mask of the new context |
| pop_valid | input | 1 | Pop request offered |
| pop_ready | output | 1 | Pop request can be accepted |
| pop_warp | input | WARP_W | Warp whose head is taken |
| resp_valid | output | 1 | Pop answer present (one cycle after accept) |
| resp_hit | output | 1 | Answer carries an entry |
| resp_pc | output | PC_W | PC of the removed head |
| resp_mask | output | MASK_W | Mask of the removed head |

## Verification
The in-line assertions watch, on every cycle, that each accepted pop is answered exactly one cycle later and never otherwise, that no pop is accepted into the list under a walk, that the walk cursor never runs off a list, that the request queue never overflows, and that a request dispatched over the threshold lands at its warp's head. Sorted placement with equal PCs, the exact number of cycles a walk blocks its warp, the switch to stack order under back-pressure, refusal when the table is exhausted, and the isolation of warps under mixed traffic can only be shown by the bench scenarios, which compare every port on every cycle against a behavioural model.

// File: rtl/csort_pkg.sv
package csort_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_WALK = 1'b1
    } walk_state_e;
endpackage

// File: rtl/csort_req_fifo.sv
module csort_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 7,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  front,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_ctl_t;

    fifo_ctl_t  ctl_d, ctl_q;
    logic [W-1:0] slot_d [DEPTH];
    logic [W-1:0] slot_q [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctl_d  = ctl_q;
        slot_d = slot_q;
        if (push) begin
            slot_d[ctl_q.wp] = push_data;
            ctl_d.wp         = bump(ctl_q.wp);
        end
        if (pop) begin
            ctl_d.rp = bump(ctl_q.rp);
        end
        case ({push, pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            ctl_q  <= ctl_d;
            slot_q <= slot_d;
        end
    end

    assign front = slot_q[ctl_q.rp];
    assign count = ctl_q.cnt;

    // R2: the queue never takes a request it has no room for
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (ctl_q.cnt < CW'(DEPTH)));
    // R9: nothing is drained from an empty queue
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (ctl_q.cnt != '0));
endmodule

// File: rtl/csort_entry_mem.sv
module csort_entry_mem #(
    parameter int DEPTH  = 32,
    parameter int PC_W   = 16,
    parameter int MASK_W = 8,
    parameter int PORTS  = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [PC_W-1:0]             wr_pc,
    input  logic [MASK_W-1:0]           wr_mask,
    input  logic [PORTS-1:0]            lk_en,
    input  logic [PORTS-1:0][IDX_W-1:0] lk_idx,
    input  logic [PORTS-1:0][PTR_W-1:0] lk_ptr,
    output logic [PC_W-1:0]             pc_o   [DEPTH],
    output logic [MASK_W-1:0]           mask_o [DEPTH],
    output logic [PTR_W-1:0]            next_o [DEPTH]
);
    localparam logic [PTR_W-1:0] NIL = {1'b1, {IDX_W{1'b0}}};

    logic [PC_W-1:0]   pc_d   [DEPTH];
    logic [PC_W-1:0]   pc_q   [DEPTH];
    logic [MASK_W-1:0] mask_d [DEPTH];
    logic [MASK_W-1:0] mask_q [DEPTH];
    logic [PTR_W-1:0]  next_d [DEPTH];
    logic [PTR_W-1:0]  next_q [DEPTH];

    always_comb begin
        pc_d   = pc_q;
        mask_d = mask_q;
        next_d = next_q;
        if (wr_en) begin
            pc_d[wr_idx]   = wr_pc;
            mask_d[wr_idx] = wr_mask;
        end
        for (int p = 0; p < PORTS; p++) begin
            if (lk_en[p]) next_d[lk_idx[p]] = lk_ptr[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pc_q[i]   <= '0;
                mask_q[i] <= '0;
                next_q[i] <= (i == DEPTH - 1) ? NIL : PTR_W'(i + 1);
            end
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            next_q <= next_d;
        end
    end

    assign pc_o   = pc_q;
    assign mask_o = mask_q;
    assign next_o = next_q;

    // R10: two link ports never target the same entry in one cycle
    generate
        for (genvar a = 0; a < PORTS; a++) begin : g_pa
            for (genvar b = a + 1; b < PORTS; b++) begin : g_pb
                a_r10_link_ports_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
                    (lk_en[a] && lk_en[b]) |-> (lk_idx[a] != lk_idx[b]));
            end
        end
    endgenerate
endmodule

// File: rtl/csort_store.sv
module csort_store
    import csort_pkg::*;
#(
    parameter int NUM_WARPS        = 4,
    parameter int ENTRIES_PER_WARP = 8,
    parameter int PC_W             = 16,
    parameter int MASK_W           = 8,
    parameter int FIFO_DEPTH       = 4,
    parameter int DEGRADE_AT       = 3,
    localparam int DEPTH  = NUM_WARPS * ENTRIES_PER_WARP,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int PTR_W  = IDX_W + 1,
    localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int REQ_W  = WARP_W + IDX_W,
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [WARP_W-1:0] ins_warp,
    input  logic [PC_W-1:0]   ins_pc,
    input  logic [MASK_W-1:0] ins_mask,
    input  logic              pop_valid,
    output logic              pop_ready,
    input  logic [WARP_W-1:0] pop_warp,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [PC_W-1:0]   resp_pc,
    output logic [MASK_W-1:0] resp_mask
);
    localparam logic [PTR_W-1:0] NIL = {1'b1, {IDX_W{1'b0}}};

    typedef struct packed {
        walk_state_e       st;
        logic [WARP_W-1:0] wwarp;
        logic [IDX_W-1:0]  widx;
        logic [PTR_W-1:0]  cur;
        logic [PTR_W-1:0]  free_head;
        logic              resp_v;
        logic              resp_hit;
        logic [PC_W-1:0]   resp_pc;
        logic [MASK_W-1:0] resp_mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [PTR_W-1:0] head_d [NUM_WARPS];
    logic [PTR_W-1:0] head_q [NUM_WARPS];

    // entry table
    logic                    wr_en;
    logic [IDX_W-1:0]        wr_idx;
    logic [2:0]              lk_en;
    logic [2:0][IDX_W-1:0]   lk_idx;
    logic [2:0][PTR_W-1:0]   lk_ptr;
    logic [PC_W-1:0]         pcs   [DEPTH];
    logic [MASK_W-1:0]       masks [DEPTH];
    logic [PTR_W-1:0]        nxt   [DEPTH];

    csort_entry_mem #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .MASK_W(MASK_W),
        .PORTS (3)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_pc  (ins_pc),
        .wr_mask(ins_mask),
        .lk_en  (lk_en),
        .lk_idx (lk_idx),
        .lk_ptr (lk_ptr),
        .pc_o   (pcs),
        .mask_o (masks),
        .next_o (nxt)
    );

    // request queue: warp and entry index of each accepted insertion
    logic              ins_fire;
    logic              fifo_pop;
    logic [REQ_W-1:0]  fifo_front;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [WARP_W-1:0] front_warp;
    logic [IDX_W-1:0]  front_idx;

    csort_req_fifo #(
        .DEPTH(FIFO_DEPTH),
        .W    (REQ_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ins_fire),
        .push_data({ins_warp, ctl_q.free_head[IDX_W-1:0]}),
        .pop      (fifo_pop),
        .front    (fifo_front),
        .count    (fifo_cnt)
    );

    assign front_warp = fifo_front[REQ_W-1:IDX_W];
    assign front_idx  = fifo_front[IDX_W-1:0];

    // port handshakes
    logic             pop_fire;
    logic [PTR_W-1:0] pop_head;
    logic [IDX_W-1:0] pop_idx;
    logic             pop_has;

    assign ins_ready = !ctl_q.free_head[PTR_W-1] && (fifo_cnt < CNT_W'(FIFO_DEPTH));
    assign ins_fire  = ins_valid && ins_ready;
    assign pop_ready = !((ctl_q.st == S_WALK) && (ctl_q.wwarp == pop_warp));
    assign pop_fire  = pop_valid && pop_ready;
    assign pop_head  = head_q[pop_warp];
    assign pop_idx   = pop_head[IDX_W-1:0];
    assign pop_has   = !pop_head[PTR_W-1];

    // next-state logic
    logic             disp;
    logic             degrade;
    logic [PTR_W-1:0] fh_after;
    logic [PTR_W-1:0] front_head;
    logic [PTR_W-1:0] walk_next;

    assign front_head = head_q[front_warp];
    assign walk_next  = nxt[ctl_q.cur[IDX_W-1:0]];

    always_comb begin
        ctl_d    = ctl_q;
        head_d   = head_q;
        wr_en    = 1'b0;
        wr_idx   = ctl_q.free_head[IDX_W-1:0];
        lk_en    = '0;
        lk_idx   = '0;
        lk_ptr   = '0;
        fifo_pop = 1'b0;
        disp     = 1'b0;
        degrade  = 1'b0;

        // allocation from the free list
        fh_after = ctl_q.free_head;
        if (ins_fire) begin
            wr_en    = 1'b1;
            fh_after = nxt[ctl_q.free_head[IDX_W-1:0]];
        end
        ctl_d.free_head = fh_after;

        // pop path: unlink head, return it to the free list
        ctl_d.resp_v    = pop_fire;
        ctl_d.resp_hit  = pop_fire && pop_has;
        ctl_d.resp_pc   = '0;
        ctl_d.resp_mask = '0;
        if (pop_fire && pop_has) begin
            ctl_d.resp_pc    = pcs[pop_idx];
            ctl_d.resp_mask  = masks[pop_idx];
            head_d[pop_warp] = nxt[pop_idx];
            lk_en[2]         = 1'b1;
            lk_idx[2]        = pop_idx;
            lk_ptr[2]        = fh_after;
            ctl_d.free_head  = pop_head;
        end

        // insertion engine
        case (ctl_q.st)
            S_IDLE: begin
                if ((fifo_cnt != '0) && !(pop_fire && (pop_warp == front_warp))) begin
                    disp     = 1'b1;
                    fifo_pop = 1'b1;
                    degrade  = (fifo_cnt >= CNT_W'(DEGRADE_AT));
                    if (degrade || front_head[PTR_W-1]
                        || (pcs[front_head[IDX_W-1:0]] > pcs[front_idx])) begin
                        lk_en[0]           = 1'b1;
                        lk_idx[0]          = front_idx;
                        lk_ptr[0]          = front_head;
                        head_d[front_warp] = {1'b0, front_idx};
                    end else begin
                        ctl_d.st    = S_WALK;
                        ctl_d.wwarp = front_warp;
                        ctl_d.widx  = front_idx;
                        ctl_d.cur   = front_head;
                    end
                end
            end
            S_WALK: begin
                if (walk_next[PTR_W-1]
                    || (pcs[walk_next[IDX_W-1:0]] > pcs[ctl_q.widx])) begin
                    lk_en[0]  = 1'b1;
                    lk_idx[0] = ctl_q.widx;
                    lk_ptr[0] = walk_next;
                    lk_en[1]  = 1'b1;
                    lk_idx[1] = ctl_q.cur[IDX_W-1:0];
                    lk_ptr[1] = {1'b0, ctl_q.widx};
                    ctl_d.st  = S_IDLE;
                end else begin
                    ctl_d.cur = walk_next;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= S_IDLE;
            ctl_q.cur       <= NIL;
            ctl_q.free_head <= '0;
            for (int w = 0; w < NUM_WARPS; w++) head_q[w] <= NIL;
        end else begin
            ctl_q  <= ctl_d;
            head_q <= head_d;
        end
    end

    assign resp_valid = ctl_q.resp_v;
    assign resp_hit   = ctl_q.resp_hit;
    assign resp_pc    = ctl_q.resp_pc;
    assign resp_mask  = ctl_q.resp_mask;

    // R6: every accepted pop is answered on the following cycle
    a_r6_resp_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |=> resp_valid);
    // R6: no answer appears without a pop one cycle earlier
    a_r6_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(pop_fire));
    // R7: a miss carries no data
    a_r7_miss_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_pc == '0 && resp_mask == '0));
    // R8: the list under a walk is never popped
    a_r8_no_pop_into_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_WALK) |-> !(pop_fire && (pop_warp == ctl_q.wwarp)));
    // R4: the walk cursor always points at a list entry
    a_r4_cursor_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_WALK) |-> !ctl_q.cur[PTR_W-1]);
    // R5: a request dispatched over the threshold becomes its warp's head
    a_r5_stack_link: assert property (@(posedge clk) disable iff (!rst_n)
        (disp && degrade) |=> (head_q[$past(front_warp)] == {1'b0, $past(front_idx)}));
endmodule

// File: tb/csort_store_tb.sv
module csort_store_tb;
    localparam int NW     = 4;
    localparam int EPW    = 8;
    localparam int PC_W   = 16;
    localparam int MASK_W = 8;
    localparam int FD     = 4;
    localparam int DEG    = 3;
    localparam int DEPTH  = NW * EPW;
    localparam int WARP_W = $clog2(NW);
    localparam int EW     = PC_W + MASK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic              ins_ready;
    logic [WARP_W-1:0] ins_warp = '0;
    logic [PC_W-1:0]   ins_pc = '0;
    logic [MASK_W-1:0] ins_mask = '0;
    logic              pop_valid = 1'b0;
    logic              pop_ready;
    logic [WARP_W-1:0] pop_warp = '0;
    logic              resp_valid;
    logic              resp_hit;
    logic [PC_W-1:0]   resp_pc;
    logic [MASK_W-1:0] resp_mask;

    always #4 clk = ~clk;

    csort_store #(
        .NUM_WARPS(NW), .ENTRIES_PER_WARP(EPW), .PC_W(PC_W), .MASK_W(MASK_W),
        .FIFO_DEPTH(FD), .DEGRADE_AT(DEG)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_warp(ins_warp),
        .ins_pc(ins_pc), .ins_mask(ins_mask),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_warp(pop_warp),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_pc(resp_pc), .resp_mask(resp_mask)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // behavioural reference model
    logic [EW-1:0]        m_list [NW][$];
    logic [WARP_W+EW-1:0] m_fifo [$];
    int                   m_free;
    bit                   m_busy;
    int                   m_wwarp, m_rem, m_pos;
    logic [EW-1:0]        m_item;
    bit                   m_rv, m_rhit;
    logic [PC_W-1:0]      m_rpc;
    logic [MASK_W-1:0]    m_rmask;

    function automatic bit m_pop_rdy(int w);
        return !(m_busy && m_wwarp == w);
    endfunction

    function automatic bit m_ins_rdy();
        return (m_free > 0) && (m_fifo.size() < FD);
    endfunction

    // number of entries walked past; also the insertion index (0 = head)
    function automatic int walk_len(int w, logic [PC_W-1:0] pc);
        int i;
        if (m_list[w].size() == 0) return 0;
        if (m_list[w][0][EW-1:MASK_W] > pc) return 0;
        i = 0;
        while (i + 1 < m_list[w].size() && m_list[w][i+1][EW-1:MASK_W] <= pc) i++;
        return i + 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) m_list[w].delete();
            m_fifo.delete();
            m_free = DEPTH; m_busy = 0; m_rv = 0; m_rhit = 0; m_rpc = '0; m_rmask = '0;
        end else begin
            bit pa, ia;
            int fsz;
            pa  = pop_valid && m_pop_rdy(pop_warp);
            ia  = ins_valid && m_ins_rdy();
            fsz = m_fifo.size();
            m_rv = pa; m_rhit = 0; m_rpc = '0; m_rmask = '0;
            if (pa && m_list[pop_warp].size() > 0) begin
                logic [EW-1:0] e;
                e = m_list[pop_warp].pop_front();
                m_rhit = 1; m_rpc = e[EW-1:MASK_W]; m_rmask = e[MASK_W-1:0];
                m_free++;
            end
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_list[m_wwarp].insert(m_pos, m_item);
                    m_busy = 0;
                end
            end else if (fsz > 0 && !(pa && pop_warp == m_fifo[0][WARP_W+EW-1:EW])) begin
                logic [WARP_W+EW-1:0] r;
                int w, k;
                r = m_fifo.pop_front();
                w = int'(r[WARP_W+EW-1:EW]);
                k = (fsz >= DEG) ? 0 : walk_len(w, r[EW-1:MASK_W]);
                if (k == 0) m_list[w].push_front(r[EW-1:0]);
                else begin
                    m_busy = 1; m_wwarp = w; m_rem = k; m_pos = k; m_item = r[EW-1:0];
                end
            end
            if (ia) begin
                m_fifo.push_back({ins_warp, ins_pc, ins_mask});
                m_free--;
            end
        end
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    bit              o_v, o_hit;
    logic [PC_W-1:0] o_pc;
    logic [MASK_W-1:0] o_mask;

    // one cycle: drive at the falling edge, compare every port, wait
    task automatic step(bit iv, int iw, int ipc, int imask, bit pv, int pw);
        ins_valid = iv; ins_warp = WARP_W'(iw); ins_pc = PC_W'(ipc); ins_mask = MASK_W'(imask);
        pop_valid = pv; pop_warp = WARP_W'(pw);
        #1;
        chk(ins_ready === m_ins_rdy(), "R2 ins_ready", ins_ready, m_ins_rdy());
        chk(pop_ready === m_pop_rdy(pw), "R8 pop_ready", pop_ready, m_pop_rdy(pw));
        chk(resp_valid === m_rv, "R6 resp_valid", resp_valid, m_rv);
        if (m_rv) begin
            chk(resp_hit === m_rhit, "R7 resp_hit", resp_hit, m_rhit);
            chk(resp_pc === m_rpc, "R3/R9/R10 resp_pc", resp_pc, m_rpc);
            chk(resp_mask === m_rmask, "R6 resp_mask", resp_mask, m_rmask);
        end
        o_v = resp_valid; o_hit = resp_hit; o_pc = resp_pc; o_mask = resp_mask;
        @(negedge clk);
    endtask

    task automatic idle(int n, int pw = 0);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, pw);
    endtask

    task automatic put(int w, int pc, int mask);
        step(1, w, pc, mask, 0, w);
        idle(14);
    endtask

    task automatic take(int w);
        step(0, 0, 0, 0, 1, w);
        step(0, 0, 0, 0, 0, w);
    endtask

    initial begin
        int blocked;
        int deg_exp [10] = '{101, 10, 20, 30, 40, 50, 60, 100, 102, 103};
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        step(0, 0, 0, 0, 0, 0);
        chk(ins_ready === 1'b1, "R1 ins_ready after reset", ins_ready, 1);
        chk(resp_valid === 1'b0, "R1 resp_valid after reset", resp_valid, 0);
        // R7: every list empty
        for (int w = 0; w < NW; w++) begin
            take(w);
            chk(o_v && !o_hit, "R7 empty pop gives miss", o_hit, 0);
        end

        // R3: sorted placement, equal PCs keep arrival order
        put(1, 50, 3); put(1, 20, 1); put(1, 80, 5); put(1, 20, 2); put(1, 60, 4);
        begin
            int ep [5] = '{20, 20, 50, 60, 80};
            int em [5] = '{1, 2, 3, 4, 5};
            for (int i = 0; i < 5; i++) begin
                take(1);
                chk(o_hit && o_pc == PC_W'(ep[i]), "R3 sorted pc", o_pc, ep[i]);
                chk(o_mask == MASK_W'(em[i]), "R3 tie order mask", o_mask, em[i]);
            end
        end

        // R4: walk past two entries blocks the warp for two cycles
        put(0, 20, 9); put(0, 50, 9); put(0, 60, 9);
        step(1, 0, 55, 7, 0, 0);
        blocked = 0;
        for (int i = 0; i < 12; i++) begin
            step(0, 0, 0, 0, 0, 0);
            if (!o_v && !pop_ready) blocked++;
        end
        chk(blocked == 2, "R4 walk length", blocked, 2);

        // R5: back-pressure switches to head linking
        for (int p = 10; p <= 60; p += 10) put(2, p, 2);
        for (int i = 0; i < 4; i++) step(1, 2, 100 + i, 6, 0, 3);
        idle(40);
        for (int i = 0; i < 10; i++) begin
            take(2);
            chk(o_hit && o_pc == PC_W'(deg_exp[i]), "R5 stack then sort order", o_pc, deg_exp[i]);
        end

        // R2: exhaust the table (warp 0 still holds 4)
        for (int i = 0; i < DEPTH - 4; i++) put(i % NW, (i * 37) % 200, i);
        chk(ins_ready === 1'b0, "R2 full table refuses", ins_ready, 0);
        step(1, 3, 5, 5, 0, 0);
        take(0);
        chk(o_hit == 1'b1, "R6 pop from full table", o_hit, 1);
        step(0, 0, 0, 0, 0, 0);
        chk(ins_ready === 1'b1, "R2 freed entry reopens", ins_ready, 1);

        // R8: walk on warp 1; warp 3 pops meanwhile, warp 1 waits
        step(1, 1, 199, 1, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 3);
        chk(pop_ready === 1'b1, "R8 other warp accepted during walk", pop_ready, 1);
        step(0, 0, 0, 0, 1, 1);
        chk(o_v && o_hit, "R8 other warp answered", o_hit, 1);
        idle(12, 1);

        // R9/R10: mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            step(r < 45, int'($urandom % NW), int'($urandom % 256), int'($urandom % 256),
                 r >= 60, int'($urandom % NW));
        end
        idle(60);
        for (int w = 0; w < NW; w++) for (int i = 0; i < 12; i++) take(w);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule